// File: doc/BRIEF.md
# Power-On Fuse Check Mode Controller

This block decides when a fuse-continuity test current may be drawn from the test-mode-select pin of a debug port. It watches the pin level through a synchronizer and follows a three-state life cycle after each power-on reset. The states are armed, active and done. While the mode is active and the pin sits low, it raises an enable for the current sink. The enable stays low once the fuse has been burned.

The mode can be entered in two ways. The first is a falling edge on the pin at any time after power-on. The second is the pin being held low when reset releases. The second rising edge seen while active ends the mode. After that the block stays done until the next power-on reset, which arms it again. Holding the pin high keeps the current off at all times. The analog sink and the debug-port state machine sit outside this block.

Top module: `fchk_ctrl`

## Requirements
- R1: While `por` is high, and after its release with `tms_pin` high, the block is armed: `check_active` and `sink_en` are 0.
- R2: If the synchronized pin level is low in the last reset cycle, `check_active` is 1 in the first cycle after `por` falls.
- R3: In the armed state, a high-to-low change on `tms_pin` sets `check_active` to 1 after the third rising clock edge following the change. That is two synchronizer edges plus one state edge.
- R4: Rising edges are counted only in the active state. The count starts from zero at every power-on reset.
- R5: In the active state, the second counted low-to-high change on `tms_pin` clears `check_active` with the same three-edge latency as R3.
- R6: Once done, no activity on `tms_pin` or `fuse_blown` raises `check_active` again; only `por` leaves that state.
- R7: `sink_en` is 1 only while `check_active` is 1 and the synchronized pin level is low; a high pin turns it off while the mode stays active.
- R8: `sink_en` is 0 whenever `fuse_blown` is 1, in the same cycle.
- R9: `sink_en` follows `tms_pin` through the two-flop synchronizer, two clock edges after a pin change.
- R10: A power-on reset during the active state discards any rising edges already counted. After re-entry, two fresh rising edges are needed to reach done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| tms_pin | input | 1 | Raw test-mode-select pin level |
| fuse_blown | input | 1 | 1 when the fuse has already been burned |
| check_active | output | 1 | Fuse check mode is active |
| sink_en | output | 1 | Enable for the fuse check current sink |

## Verification
Two events can land on the same clock: the release of `por` and a pin transition travelling through the synchronizer. The bench drops `tms_pin` low in the same cycle that `por` falls. The edge then reaches the edge detector only after release. The other path to activation, the low level sampled during reset, is also exercised, and the two paths are kept apart. The cycle-accurate model in the bench predicts which path wins. It compares `check_active` and `sink_en` with the design on every clock.

// File: rtl/fchk_pkg.sv
package fchk_pkg;

    typedef enum logic [1:0] {
        FC_ARMED  = 2'd0,
        FC_ACTIVE = 2'd1,
        FC_DONE   = 2'd2
    } fc_state_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } tms_evt_t;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/fchk_sync.sv
module fchk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) chain <= d;
        end else begin : g_multi
            always_ff @(posedge clk) chain <= {chain[STAGES-2:0], d};
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fchk_edge.sv
module fchk_edge
    import fchk_pkg::*;
(
    input  logic     clk,
    input  logic     lvl,
    output tms_evt_t evt
);
    logic prev_q;

    // The previous level is tracked through reset as well, so no edge is
    // invented at reset release.
    always_ff @(posedge clk) prev_q <= lvl;

    always_comb begin
        evt.level = lvl;
        evt.rise  = ~prev_q & lvl;
        evt.fall  = prev_q & ~lvl;
    end
endmodule

// File: rtl/fchk_fsm.sv
module fchk_fsm
    import fchk_pkg::*;
#(
    parameter int RISE_LIMIT = 2
) (
    input  logic      clk,
    input  logic      por,
    input  tms_evt_t  evt,
    output fc_state_e state
);
    localparam int CW = cnt_width(RISE_LIMIT);
    localparam logic [CW-1:0] LAST = CW'(RISE_LIMIT - 1);

    fc_state_e      st_q, st_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            FC_ARMED: begin
                if (evt.fall) st_d = FC_ACTIVE;
            end
            FC_ACTIVE: begin
                if (evt.rise) begin
                    if (cnt_q == LAST) begin
                        st_d  = FC_DONE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            FC_DONE: st_d = FC_DONE;
            default: st_d = FC_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (por) begin
            st_q  <= evt.level ? FC_ARMED : FC_ACTIVE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/fchk_ctrl.sv
module fchk_ctrl
    import fchk_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RISE_LIMIT  = 2
) (
    input  logic clk,
    input  logic por,
    input  logic tms_pin,
    input  logic fuse_blown,
    output logic check_active,
    output logic sink_en
);
    logic      tms_lvl;
    tms_evt_t  tms_evt;
    fc_state_e state_q;

    fchk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (tms_pin),
        .q   (tms_lvl)
    );

    fchk_edge u_edge (
        .clk (clk),
        .lvl (tms_lvl),
        .evt (tms_evt)
    );

    fchk_fsm #(.RISE_LIMIT(RISE_LIMIT)) u_fsm (
        .clk   (clk),
        .por   (por),
        .evt   (tms_evt),
        .state (state_q)
    );

    assign check_active = (state_q == FC_ACTIVE);
    assign sink_en      = check_active & ~tms_lvl & ~fuse_blown;
endmodule

// File: rtl/fchk_ctrl_chk.sv
module fchk_ctrl_chk
    import fchk_pkg::*;
(
    input logic      clk,
    input logic      por,
    input logic      tms_s,
    input fc_state_e st,
    input logic      fuse_blown,
    input logic      check_active,
    input logic      sink_en
);
    p_done_sticky_r6: assert property (@(posedge clk) disable iff (por)
        (st == FC_DONE) |=> (st == FC_DONE));

    p_no_rearm_r5: assert property (@(posedge clk) disable iff (por)
        (st == FC_ACTIVE) |=> (st != FC_ARMED));

    p_armed_skip_r3: assert property (@(posedge clk) disable iff (por)
        (st == FC_ARMED) |=> (st != FC_DONE));

    p_sink_gate_r7: assert property (@(posedge clk) disable iff (por)
        sink_en |-> (check_active && !tms_s));

    p_fuse_block_r8: assert property (@(posedge clk) disable iff (por)
        fuse_blown |-> !sink_en);

    p_flag_state_r1: assert property (@(posedge clk) disable iff (por)
        check_active |-> (st == FC_ACTIVE));
endmodule

bind fchk_ctrl fchk_ctrl_chk u_chk (
    .clk          (clk),
    .por          (por),
    .tms_s        (tms_lvl),
    .st           (state_q),
    .fuse_blown   (fuse_blown),
    .check_active (check_active),
    .sink_en      (sink_en)
);

// File: tb/fchk_ctrl_test.sv
`timescale 1ns/1ps
module fchk_ctrl_test;
    logic clk = 1'b0;
    logic por = 1'b1;
    logic tms_pin = 1'b1;
    logic fuse_blown = 1'b0;
    logic check_active, sink_en;

    int checks = 0;
    int fails  = 0;
    string req = "R1";
    bit done = 1'b0;

    always #10 clk = ~clk;

    fchk_ctrl uut (
        .clk          (clk),
        .por          (por),
        .tms_pin      (tms_pin),
        .fuse_blown   (fuse_blown),
        .check_active (check_active),
        .sink_en      (sink_en)
    );

    // Reference model: 0 armed, 1 active, 2 done
    logic hist[$] = '{1'b1, 1'b1, 1'b1};
    int m_st = 0;
    int m_rises = 0;
    int por_run = 0;

    always @(posedge clk) begin
        logic cur, old;
        cur = hist[1];
        old = hist[2];
        if (por) begin
            m_st = cur ? 0 : 1;
            m_rises = 0;
            por_run++;
        end else begin
            por_run = 0;
            if (m_st == 0 && old && !cur) m_st = 1;
            else if (m_st == 1 && !old && cur) begin
                m_rises++;
                if (m_rises == 2) m_st = 2;
            end
        end
        hist.push_front(tms_pin);
        if (hist.size() > 4) void'(hist.pop_back());
    end

    always @(negedge clk) begin
        logic e_act, e_sink;
        if (!(por && por_run < 3) && !done) begin
            e_act  = (m_st == 1);
            e_sink = e_act && !hist[1] && !fuse_blown;
            checks++;
            if (check_active !== e_act) begin
                fails++;
                $display("FAIL %s check_active actual=%b expected=%b t=%0t", req, check_active, e_act, $time);
            end
            checks++;
            if (sink_en !== e_sink) begin
                fails++;
                $display("FAIL %s sink_en actual=%b expected=%b t=%0t", req, sink_en, e_sink, $time);
            end
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #2;
    endtask

    initial begin
        cyc(5);
        req = "R1"; por = 0; cyc(4);
        req = "R3"; tms_pin = 0; cyc(6);
        req = "R8"; fuse_blown = 1; cyc(2);
        fuse_blown = 0;
        req = "R7"; tms_pin = 1; cyc(4);
        req = "R9"; tms_pin = 0; cyc(4);
        req = "R5"; tms_pin = 1; cyc(5);
        req = "R6";
        for (int k = 0; k < 4; k++) begin
            tms_pin = ~tms_pin; fuse_blown = k[0]; cyc(3);
        end
        fuse_blown = 0;
        req = "R2"; tms_pin = 0; por = 1; cyc(5);
        por = 0; cyc(4);
        req = "R10"; tms_pin = 1; cyc(4);
        por = 1; cyc(4);
        por = 0; cyc(2);
        tms_pin = 0; cyc(4);
        req = "R4"; tms_pin = 1; cyc(4);
        tms_pin = 0; cyc(4);
        req = "R5"; tms_pin = 1; cyc(5);
        req = "R3"; tms_pin = 1; por = 1; cyc(5);
        tms_pin = 0; por = 0; cyc(6);
        tms_pin = 1; cyc(3);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule